// File: doc/BRIEF.md
# Parallel ATA Read/Write Strobe Sequencer

This block drives the active-low read and write strobes of one parallel ATA channel. A host-side controller presents a 32-bit timing word, a read/write select, a flag that marks the access as a task-file register access rather than a data-port transfer, a DMA flag and a word count, then pulses start. The block captures everything it needs on that edge, runs a first-cycle setup delay, and then produces one active (low) and one inactive (high) strobe phase per word. It raises busy for the whole burst and pulses done for a single clock at the end.

The timing word holds two independent timing sets. Data-port transfers use bits 3:0 (inactive), 8:4 (active) and 24:22 (setup). Task-file register accesses use bits 12:9 (inactive), 17:13 (active) and 27:25 (setup). Every count field lasts its value plus one clock. The upper nibble's enable bits are captured and exposed unchanged, except the FIFO enable, which is forced by the transfer type. Bits 21:18 are not used by this block.

Top module: `ata_strobe_gen`

## Requirements
- R1: While reset is held and afterwards until the first start, both strobes are high and busy, done and all four mode outputs are low.
- R2: A data-port burst accepted at a clock edge holds both strobes high for bits 24:22 + 1 clocks, then for each word drives the selected strobe low for bits 8:4 + 1 clocks and high for bits 3:0 + 1 clocks.
- R3: A task-file access uses bits 27:25 + 1 clocks of setup, bits 17:13 + 1 clocks active and bits 12:9 + 1 clocks inactive.
- R4: With write select 1 only the write strobe goes low; with 0 only the read strobe goes low; the two are never low together.
- R5: A task-file access is always exactly one word whatever the word count; a data burst with word count 0 is one word.
- R6: Busy is high from the clock after an accepted start through the done clock, and is low otherwise.
- R7: Done is high for exactly one clock, directly after the last inactive phase, and the block is idle in the next clock.
- R8: The timing word and controls are captured when start is accepted; changes to them during a burst do not alter the strobe timing of that burst.
- R9: At an accepted start, UDMA enable takes bit 28, DMA enable bit 29 and PIO bus-master enable bit 30; FIFO enable is set for a DMA transfer and clear for a PIO transfer; all four are held until the next accepted start.
- R10: A start asserted while busy, including in the done clock, is ignored; a start seen in an idle clock is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Burst request, accepted only while idle |
| write_i | input | 1 | 1 selects the write strobe, 0 the read strobe |
| taskfile_i | input | 1 | 1 selects task-file register timing and a single word |
| dma_i | input | 1 | 1 marks a DMA transfer (forces FIFO enable on) |
| len_i | input | LEN_W | Words in a data burst (0 treated as 1) |
| timing_i | input | 32 | Timing word |
| dior_n_o | output | 1 | Active-low read strobe |
| diow_n_o | output | 1 | Active-low write strobe |
| busy_o | output | 1 | Burst in progress |
| done_o | output | 1 | One-clock end-of-burst pulse |
| udma_en_o | output | 1 | Captured UDMA enable |
| dma_en_o | output | 1 | Captured DMA enable |
| pio_master_o | output | 1 | Captured PIO bus-master enable |
| fifo_en_o | output | 1 | FIFO enable forced by transfer type |

## Verification
A wrong phase counter or a stale captured field shows up at the strobes within one clock, as a low or high phase that is one or more clocks too long or short against the reference schedule. A wrong word counter appears as an extra or missing strobe pulse and a misplaced done pulse at the end of the burst. A mode or state register that reloads mid-burst is visible the next clock as a mode output change or a busy or strobe value that departs from the schedule built at acceptance.

// File: rtl/ata_strobe_gen.sv
module ata_strobe_gen #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             write_i,
  input  logic             taskfile_i,
  input  logic             dma_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [31:0]      timing_i,
  output logic             dior_n_o,
  output logic             diow_n_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             udma_en_o,
  output logic             dma_en_o,
  output logic             pio_master_o,
  output logic             fifo_en_o
);

  localparam int CW = 5;

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_ACT, S_INACT, S_DONE} st_t;

  st_t              st;
  logic [CW-1:0]    cnt;
  logic [CW-1:0]    act_q;
  logic [3:0]       inact_q;
  logic [LEN_W-1:0] left;
  logic             wr_q;
  logic [3:0]       mode_q;

  wire [2:0]       setup_sel = taskfile_i ? timing_i[27:25] : timing_i[24:22];
  wire [4:0]       act_sel   = taskfile_i ? timing_i[17:13] : timing_i[8:4];
  wire [3:0]       inact_sel = taskfile_i ? timing_i[12:9]  : timing_i[3:0];
  wire [LEN_W-1:0] words     = (taskfile_i || len_i == '0) ? LEN_W'(1) : len_i;
  wire             unused_bits = ^{timing_i[31], timing_i[21:18]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      act_q   <= '0;
      inact_q <= '0;
      left    <= '0;
      wr_q    <= 1'b0;
      mode_q  <= '0;
    end else begin
      case (st)
        S_IDLE: if (start_i) begin
          st      <= S_SETUP;
          cnt     <= CW'(setup_sel);
          act_q   <= act_sel;
          inact_q <= inact_sel;
          left    <= words;
          wr_q    <= write_i;
          mode_q  <= {dma_i, timing_i[30:28]};
        end
        S_SETUP: if (cnt == '0) begin
          st  <= S_ACT;
          cnt <= act_q;
        end else cnt <= cnt - 1'b1;
        S_ACT: if (cnt == '0) begin
          st  <= S_INACT;
          cnt <= CW'(inact_q);
        end else cnt <= cnt - 1'b1;
        S_INACT: if (cnt == '0) begin
          if (left == LEN_W'(1)) st <= S_DONE;
          else begin
            left <= left - 1'b1;
            st   <= S_ACT;
            cnt  <= act_q;
          end
        end else cnt <= cnt - 1'b1;
        S_DONE:  st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign dior_n_o     = !(st == S_ACT && !wr_q);
  assign diow_n_o     = !(st == S_ACT &&  wr_q);
  assign busy_o       = (st != S_IDLE);
  assign done_o       = (st == S_DONE);
  assign udma_en_o    = mode_q[0];
  assign dma_en_o     = mode_q[1];
  assign pio_master_o = mode_q[2];
  assign fifo_en_o    = mode_q[3];

  a_r1_idle_strobes_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (dior_n_o && diow_n_o));

  a_r4_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(!dior_n_o && !diow_n_o));

  a_r6_strobe_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (!dior_n_o || !diow_n_o) |-> (busy_o && !done_o));

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && !busy_o));

  a_r5_taskfile_one_word: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && taskfile_i) |=> (left == LEN_W'(1)));

  a_r9_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> $stable(mode_q));

  a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o && start_i) |=> busy_o);

endmodule

// File: tb/ata_strobe_gen_bench.sv
module ata_strobe_gen_bench;
  localparam int LEN_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, write_i = 1'b0, taskfile_i = 1'b0, dma_i = 1'b0;
  logic [LEN_W-1:0] len_i = '0;
  logic [31:0] timing_i = '0;
  logic dior_n_o, diow_n_o, busy_o, done_o;
  logic udma_en_o, dma_en_o, pio_master_o, fifo_en_o;

  always #10 clk = ~clk;

  ata_strobe_gen #(.LEN_W(LEN_W)) u_ata_strobe_gen (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .write_i(write_i),
    .taskfile_i(taskfile_i), .dma_i(dma_i), .len_i(len_i), .timing_i(timing_i),
    .dior_n_o(dior_n_o), .diow_n_o(diow_n_o), .busy_o(busy_o), .done_o(done_o),
    .udma_en_o(udma_en_o), .dma_en_o(dma_en_o), .pio_master_o(pio_master_o),
    .fifo_en_o(fifo_en_o));

  int total = 0, bad = 0, cycles = 0, pulses = 0;
  bit chk_en = 1'b0;

  // reference model: {dior_n, diow_n, busy, done} per future cycle
  logic [3:0] q[$];
  logic [3:0] cur = 4'b1100;
  logic [3:0] emode = 4'b0000;
  logic       prev_idle_strobe = 1'b1;

  function automatic logic [31:0] mk(int di, int da, int ti, int ta, int ds, int ts, logic [3:0] m);
    return {m, 3'(ts), 3'(ds), 4'b0101, 5'(ta), 4'(ti), 5'(da), 4'(di)};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete();
      cur = 4'b1100;
      emode = 4'b0000;
    end else if (q.size() > 0) begin
      cur = q.pop_front();
    end else if (cur[1] == 1'b0 && start_i) begin
      int s, a, i, n;
      s = taskfile_i ? int'(timing_i[27:25]) : int'(timing_i[24:22]);
      a = taskfile_i ? int'(timing_i[17:13]) : int'(timing_i[8:4]);
      i = taskfile_i ? int'(timing_i[12:9])  : int'(timing_i[3:0]);
      n = taskfile_i ? 1 : ((len_i == 0) ? 1 : int'(len_i));
      for (int k = 0; k <= s; k++) q.push_back(4'b1110);
      for (int w = 0; w < n; w++) begin
        for (int k = 0; k <= a; k++) q.push_back(write_i ? 4'b1010 : 4'b0110);
        for (int k = 0; k <= i; k++) q.push_back(4'b1110);
      end
      q.push_back(4'b1111);
      emode = {dma_i, timing_i[30:28]};
      cur = q.pop_front();
    end else begin
      cur = 4'b1100;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (prev_idle_strobe && !(dior_n_o && diow_n_o)) pulses++;
    prev_idle_strobe = dior_n_o && diow_n_o;
  end

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h at cycle %0d", req, got, exp, cycles);
    end
  endtask

  always @(negedge clk) if (chk_en) begin
    check("R2 R3 R4 strobes", {dior_n_o, diow_n_o}, cur[3:2]);
    check("R6 R10 busy", busy_o, cur[1]);
    check("R7 done", done_o, cur[0]);
    check("R8 R9 modes", {fifo_en_o, pio_master_o, dma_en_o, udma_en_o}, emode);
  end

  task automatic burst(logic [31:0] t, logic wr, logic tf, int len, logic dm, int exp_words, string req);
    @(negedge clk);
    timing_i = t; write_i = wr; taskfile_i = tf; len_i = LEN_W'(len); dma_i = dm;
    start_i = 1'b1; pulses = 0;
    @(negedge clk);
    start_i = 1'b0;
    while (busy_o) @(negedge clk);
    check(req, pulses, exp_words);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset strobes", {dior_n_o, diow_n_o, busy_o, done_o}, 4'b1100);
    check("R1 reset modes", {udma_en_o, dma_en_o, pio_master_o, fifo_en_o}, 4'b0000);
    rst_n = 1'b1;
    @(negedge clk);
    chk_en = 1'b1;
    check("R1 idle after reset", {dior_n_o, diow_n_o, busy_o}, 3'b110);

    // R2 data read, three words
    burst(mk(1, 3, 5, 7, 2, 4, 4'b0000), 1'b0, 1'b0, 3, 1'b0, 3, "R2 data read words");
    // R2 R4 R9 data write, DMA, mode bits set
    burst(mk(2, 1, 3, 4, 1, 6, 4'b0111), 1'b1, 1'b0, 2, 1'b1, 2, "R4 data write words");
    check("R9 fifo forced on for DMA", fifo_en_o, 1'b1);
    // R3 R5 task-file access with large count: one word
    burst(mk(1, 1, 6, 9, 0, 5, 4'b1000), 1'b0, 1'b1, 5, 1'b0, 1, "R5 taskfile single word");
    check("R9 fifo forced off for PIO", fifo_en_o, 1'b0);
    burst(mk(0, 0, 2, 3, 0, 7, 4'b0010), 1'b1, 1'b1, 0, 1'b0, 1, "R3 taskfile write");
    // R5 zero count data burst
    burst(mk(2, 2, 0, 0, 3, 0, 4'b0000), 1'b0, 1'b0, 0, 1'b0, 1, "R5 zero count one word");
    // minimum and maximum fields
    burst(mk(0, 0, 0, 0, 0, 0, 4'b0000), 1'b1, 1'b0, 4, 1'b0, 4, "R2 minimum timing");
    burst(mk(15, 31, 15, 31, 7, 7, 4'b0101), 1'b0, 1'b0, 2, 1'b1, 2, "R2 maximum timing");

    // R8 R10: new start and new timing while busy must not disturb the burst
    @(negedge clk);
    timing_i = mk(1, 2, 1, 1, 1, 1, 4'b0001); write_i = 1'b0; taskfile_i = 1'b0;
    len_i = 8'd2; dma_i = 1'b0; start_i = 1'b1; pulses = 0;
    @(negedge clk);
    start_i = 1'b0;
    repeat (3) @(negedge clk);
    timing_i = mk(9, 20, 9, 20, 6, 6, 4'b0110); write_i = 1'b1; len_i = 8'd7; dma_i = 1'b1;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (busy_o) @(negedge clk);
    check("R10 start while busy ignored", pulses, 2);
    check("R8 modes kept from capture", {fifo_en_o, udma_en_o}, 2'b01);

    // R10 start held across done: accepted again only after an idle clock
    @(negedge clk);
    timing_i = mk(0, 1, 0, 0, 0, 0, 4'b0000); write_i = 1'b1; len_i = 8'd1; dma_i = 1'b0;
    start_i = 1'b1; pulses = 0;
    repeat (14) @(negedge clk);
    start_i = 1'b0;
    while (busy_o) @(negedge clk);
    check("R10 back to back bursts", pulses, 3);

    // R1 reset in the middle of a burst
    @(negedge clk);
    timing_i = mk(3, 5, 0, 0, 2, 0, 4'b0111); len_i = 8'd4; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (4) @(negedge clk);
    chk_en = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset mid burst", {dior_n_o, diow_n_o, busy_o, done_o, udma_en_o}, 5'b11000);
    rst_n = 1'b1;
    @(negedge clk);
    chk_en = 1'b1;
    repeat (3) @(negedge clk);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired, requirement R7 never reached done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule